// File: doc/BRIEF.md
# Ethernet MAC Interrupt Status Aggregator

This block gathers the event sources of an Ethernet MAC into one 16-bit read-only status word at register offset 0x38 and drives one combined interrupt line. It owns the 64-bit compare of the running system time against a programmed target, made from a high and a low 32-bit word. It also owns the clear-on-read flag that this compare raises. The transmit and receive statistics-counter interrupt registers come in only as pending-bit vectors. The power-management wake-up logic comes in as a power-down level, two received-frame pulses and a strobe that marks a read of the power-management control register.

Each status bit follows its own clearing rule:

- **Trigger flag (bit 9).** It is raised once per target programming and cleared by reading this register. A small state machine holds it in one of four states:
  - `TS_ARMED`: waiting for a match.
  - `TS_PEND`: flag pending.
  - `TS_PEND_REARM`: flag pending, and a new target has been written.
  - `TS_SPENT`: flag cleared, waiting for a new target.

  Its transitions:
  - `TS_ARMED`→`TS_PEND` when the time reaches the target.
  - `TS_PEND`→`TS_SPENT` on a status read.
  - `TS_PEND`→`TS_ARMED` on a status read together with a target write.
  - `TS_PEND`→`TS_PEND_REARM` on a target write alone.
  - `TS_PEND_REARM`→`TS_ARMED` on a status read.
  - `TS_SPENT`→`TS_ARMED` on a target write.
- **Statistics bits (6, 5 and 4).** They follow the level of the counter interrupt vectors with no storage.
- **Wake flag (bit 3).** A second machine has the states `PM_QUIET` and `PM_WOKEN`. `PM_QUIET`→`PM_WOKEN` on a wake event seen in power-down. `PM_WOKEN`→`PM_QUIET` on a power-management register read that has no wake event in the same cycle.

Top module: `macirq_status`

## Requirements
- R1: After reset, a read of offset 0x38 returns 0x0000 and the interrupt output is low.
- R2: Bit 9 is set on the clock edge at which, in `TS_ARMED`, the 64-bit system time is greater than or equal to {target high, target low}. The high word decides, and the low word breaks a tie, including equality.
- R3: A read of offset 0x38 returns the value the word had before that clock edge, and clears bit 9 at that same edge.
- R4: If the trigger match and a status read fall in the same cycle, the set wins. The read returns bit 9 as 0, and the flag is pending afterwards.
- R5: After a clear-on-read, bit 9 does not set again while the match stays true until a target write strobe arrives. A target write that arrives while the flag is pending is remembered, so the next read re-arms the compare.
- R6: Bit 6 is the OR of the transmit counter interrupt vector, and bit 5 is the OR of the receive vector. Bit 4 is bit 6 OR bit 5. Reads do not change them.
- R7: Bit 3 sets when a magic packet or a wake-up frame pulse arrives while power-down is high. Such pulses while power-down is low are ignored.
- R8: Bit 3 stays set across status reads and the end of power-down, and clears only on the power-management register read strobe. A wake event in the same cycle as that strobe keeps bit 3 set.
- R9: Bits 15:10, 8:7 and 2:0 always read 0.
- R10: The interrupt output is the OR of (bit 9 and not ts_mask), (bit 4 and not mmc_mask) and (bit 3 and not pmt_mask).
- R11: A read at any other offset returns 0 and leaves bit 9 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Register read offset |
| rd_data | output | DATA_W | Read data, valid the cycle after the strobe |
| sys_time | input | TIME_W | Running system time |
| tgt_hi | input | TIME_W/2 | Target time, upper word |
| tgt_lo | input | TIME_W/2 | Target time, lower word |
| tgt_wr | input | 1 | Pulse: the target words were rewritten |
| tx_cnt_irq | input | TX_W | Pending bits of the transmit counter interrupt register |
| rx_cnt_irq | input | RX_W | Pending bits of the receive counter interrupt register |
| pwr_down | input | 1 | Power-down mode active |
| magic_rx | input | 1 | Pulse: magic packet received |
| wkfrm_rx | input | 1 | Pulse: wake-up frame received |
| pm_rd | input | 1 | Pulse: power-management control register was read |
| ts_mask | input | 1 | 1 blocks bit 9 from the interrupt |
| mmc_mask | input | 1 | 1 blocks bit 4 from the interrupt |
| pmt_mask | input | 1 | 1 blocks bit 3 from the interrupt |
| irq_out | output | 1 | Combined interrupt |

## Verification
The bench places the system time a few counts either side of targets that straddle the 32-bit word boundary, including exact equality. A compare that ignored the low word, or used strict greater-than, would then show a wrong bit 9. It reads the register while bit 9 is held high by the time having passed the target. A design that re-fires would show 1 again without a target write, and one that drops a target write made while the flag is pending would stay silent after the read. It also places a match, or a wake event, in the same cycle as the clearing read. A design where the clear wins would lose that event. Full sweeps over the counter vectors and over every combination of pending sources and masks expose a wrong bit mapping or a wrong interrupt gate.

// File: rtl/macirq_pkg.sv
package macirq_pkg;

    // Trigger flag machine
    typedef enum logic [1:0] {
        TS_ARMED      = 2'd0,
        TS_PEND       = 2'd1,
        TS_PEND_REARM = 2'd2,
        TS_SPENT      = 2'd3
    } ts_state_t;

    // Wake flag machine
    typedef enum logic {
        PM_QUIET = 1'b0,
        PM_WOKEN = 1'b1
    } pm_state_t;

    // Bit positions in the status word (decoded by software)
    localparam int BIT_TS  = 9;
    localparam int BIT_MTX = 6;
    localparam int BIT_MRX = 5;
    localparam int BIT_MMC = 4;
    localparam int BIT_PMT = 3;

    localparam int STAT_W = 16;

endpackage

// File: rtl/ts_cmp.sv
module ts_cmp #(
    parameter int TIME_W = 64,
    localparam int HALF_W = TIME_W / 2
) (
    input  logic [TIME_W-1:0] sys_time,
    input  logic [HALF_W-1:0] tgt_hi,
    input  logic [HALF_W-1:0] tgt_lo,
    output logic              reached
);

    logic [HALF_W-1:0] now_hi;
    logic [HALF_W-1:0] now_lo;
    logic              hi_above;
    logic              hi_same;
    logic              lo_at_least;

    assign now_hi = sys_time[TIME_W-1:HALF_W];
    assign now_lo = sys_time[HALF_W-1:0];

    // Word-split compare: the upper word decides, the lower word breaks a tie
    always_comb begin
        hi_above    = now_hi > tgt_hi;
        hi_same     = now_hi == tgt_hi;
        lo_at_least = now_lo >= tgt_lo;
        reached     = hi_above | (hi_same & lo_at_least);
    end

endmodule

// File: rtl/ts_trigger.sv
module ts_trigger
    import macirq_pkg::*;
#(
    parameter int TIME_W = 64,
    localparam int HALF_W = TIME_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] sys_time,
    input  logic [HALF_W-1:0] tgt_hi,
    input  logic [HALF_W-1:0] tgt_lo,
    input  logic              tgt_wr,
    input  logic              rd_clr,
    output logic              flag
);

    ts_state_t state;
    ts_state_t state_nx;
    logic      reached;

    ts_cmp #(.TIME_W(TIME_W)) u_cmp (
        .sys_time (sys_time),
        .tgt_hi   (tgt_hi),
        .tgt_lo   (tgt_lo),
        .reached  (reached)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state <= TS_ARMED;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            // A match always wins over a read in the same cycle
            TS_ARMED: begin
                if (reached) state_nx = TS_PEND;
            end
            TS_PEND: begin
                if (rd_clr && tgt_wr) state_nx = TS_ARMED;
                else if (rd_clr)      state_nx = TS_SPENT;
                else if (tgt_wr)      state_nx = TS_PEND_REARM;
            end
            TS_PEND_REARM: begin
                if (rd_clr) state_nx = TS_ARMED;
            end
            TS_SPENT: begin
                if (tgt_wr) state_nx = TS_ARMED;
            end
        endcase
    end

    always_comb begin
        unique case (state)
            TS_PEND, TS_PEND_REARM: flag = 1'b1;
            TS_ARMED, TS_SPENT:     flag = 1'b0;
        endcase
    end

    p_set_on_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TS_ARMED && reached) |=> flag);

    p_clear_on_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TS_PEND && rd_clr) |=> !flag);

    p_no_refire_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TS_SPENT && !tgt_wr) |=> !flag);

    p_rearm_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TS_PEND && tgt_wr && !rd_clr) |=> (flag && state == TS_PEND_REARM));

endmodule

// File: rtl/pmt_flag.sv
module pmt_flag
    import macirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_down,
    input  logic magic_rx,
    input  logic wkfrm_rx,
    input  logic pm_rd,
    output logic flag
);

    pm_state_t state;
    pm_state_t state_nx;
    logic      wake;

    assign wake = pwr_down & (magic_rx | wkfrm_rx);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= PM_QUIET;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            PM_QUIET: if (wake)            state_nx = PM_WOKEN;
            PM_WOKEN: if (pm_rd && !wake)  state_nx = PM_QUIET;
        endcase
    end

    always_comb begin
        unique case (state)
            PM_WOKEN: flag = 1'b1;
            PM_QUIET: flag = 1'b0;
        endcase
    end

    p_awake_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PM_QUIET && !pwr_down) |=> !flag);

    p_hold_until_pmread_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !pm_rd) |=> flag);

endmodule

// File: rtl/mmc_summary.sv
module mmc_summary #(
    parameter int TX_W = 8,
    parameter int RX_W = 8
) (
    input  logic [TX_W-1:0] tx_cnt_irq,
    input  logic [RX_W-1:0] rx_cnt_irq,
    output logic            tx_any,
    output logic            rx_any,
    output logic            both_any
);

    always_comb begin
        tx_any   = |tx_cnt_irq;
        rx_any   = |rx_cnt_irq;
        both_any = tx_any | rx_any;
    end

endmodule

// File: rtl/macirq_status.sv
module macirq_status
    import macirq_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int REG_OFS = 'h38,
    parameter int DATA_W  = STAT_W,
    parameter int TIME_W  = 64,
    parameter int TX_W    = 8,
    parameter int RX_W    = 8,
    localparam int HALF_W = TIME_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [TIME_W-1:0] sys_time,
    input  logic [HALF_W-1:0] tgt_hi,
    input  logic [HALF_W-1:0] tgt_lo,
    input  logic              tgt_wr,
    input  logic [TX_W-1:0]   tx_cnt_irq,
    input  logic [RX_W-1:0]   rx_cnt_irq,
    input  logic              pwr_down,
    input  logic              magic_rx,
    input  logic              wkfrm_rx,
    input  logic              pm_rd,
    input  logic              ts_mask,
    input  logic              mmc_mask,
    input  logic              pmt_mask,
    output logic              irq_out
);

    localparam logic [ADDR_W-1:0] OFS = ADDR_W'(REG_OFS);
    localparam logic [DATA_W-1:0] LIVE_BITS =
        DATA_W'((1 << BIT_TS) | (1 << BIT_MTX) | (1 << BIT_MRX) |
                (1 << BIT_MMC) | (1 << BIT_PMT));

    logic              hit;
    logic              ts_flag;
    logic              pmt_on;
    logic              mtx_on;
    logic              mrx_on;
    logic              mmc_on;
    logic [DATA_W-1:0] word;

    assign hit = rd_en && (rd_addr == OFS);

    ts_trigger #(.TIME_W(TIME_W)) u_ts (
        .clk      (clk),
        .rst_n    (rst_n),
        .sys_time (sys_time),
        .tgt_hi   (tgt_hi),
        .tgt_lo   (tgt_lo),
        .tgt_wr   (tgt_wr),
        .rd_clr   (hit),
        .flag     (ts_flag)
    );

    pmt_flag u_pmt (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_down (pwr_down),
        .magic_rx (magic_rx),
        .wkfrm_rx (wkfrm_rx),
        .pm_rd    (pm_rd),
        .flag     (pmt_on)
    );

    mmc_summary #(.TX_W(TX_W), .RX_W(RX_W)) u_mmc (
        .tx_cnt_irq (tx_cnt_irq),
        .rx_cnt_irq (rx_cnt_irq),
        .tx_any     (mtx_on),
        .rx_any     (mrx_on),
        .both_any   (mmc_on)
    );

    // Assemble the status word; unlisted bits stay zero
    always_comb begin
        word          = '0;
        word[BIT_TS]  = ts_flag;
        word[BIT_MTX] = mtx_on;
        word[BIT_MRX] = mrx_on;
        word[BIT_MMC] = mmc_on;
        word[BIT_PMT] = pmt_on;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)   rd_data <= '0;
        else if (hit) rd_data <= word;
        else          rd_data <= '0;
    end

    always_comb begin
        irq_out = (ts_flag & ~ts_mask) | (mmc_on & ~mmc_mask) | (pmt_on & ~pmt_mask);
    end

    p_reserved_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~LIVE_BITS) == '0);

    p_summary_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[BIT_MMC] == (rd_data[BIT_MTX] | rd_data[BIT_MRX]));

    p_quiet_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ts_flag && !mmc_on && !pmt_on) |-> !irq_out);

    p_miss_reads_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr != OFS) |=> rd_data == '0);

endmodule

// File: tb/test_macirq_status.sv
module test_macirq_status;

    localparam int CLK_PERIOD = 10;
    localparam int TX_W = 3;
    localparam int RX_W = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [63:0] sys_time = '0;
    logic [31:0] tgt_hi = '1;
    logic [31:0] tgt_lo = '1;
    logic        tgt_wr = 1'b0;
    logic [TX_W-1:0] tx_cnt_irq = '0;
    logic [RX_W-1:0] rx_cnt_irq = '0;
    logic        pwr_down = 1'b0;
    logic        magic_rx = 1'b0;
    logic        wkfrm_rx = 1'b0;
    logic        pm_rd = 1'b0;
    logic        ts_mask = 1'b0;
    logic        mmc_mask = 1'b0;
    logic        pmt_mask = 1'b0;
    logic        irq_out;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    macirq_status #(.TX_W(TX_W), .RX_W(RX_W)) i_macirq_status (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .sys_time(sys_time), .tgt_hi(tgt_hi), .tgt_lo(tgt_lo), .tgt_wr(tgt_wr),
        .tx_cnt_irq(tx_cnt_irq), .rx_cnt_irq(rx_cnt_irq), .pwr_down(pwr_down),
        .magic_rx(magic_rx), .wkfrm_rx(wkfrm_rx), .pm_rd(pm_rd),
        .ts_mask(ts_mask), .mmc_mask(mmc_mask), .pmt_mask(pmt_mask), .irq_out(irq_out)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_read(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic set_target(input logic [63:0] t);
        tgt_hi = t[63:32];
        tgt_lo = t[31:0];
    endtask

    // Leaves the trigger machine armed with no flag, wake flag cleared, counters idle
    task automatic clear_all();
        @(negedge clk);
        tx_cnt_irq = '0; rx_cnt_irq = '0; pwr_down = 1'b0;
        sys_time = '0; set_target('1);
        rd_en = 1'b1; rd_addr = 8'h38; pm_rd = 1'b1; tgt_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0; pm_rd = 1'b0; tgt_wr = 1'b0;
    endtask

    task automatic pulse_tgt_wr();
        @(negedge clk); tgt_wr = 1'b1;
        @(posedge clk);
        @(negedge clk); tgt_wr = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] d;
        logic [63:0] tv [4];
        tv[0] = 64'h0000_0005_0000_0000;
        tv[1] = 64'h0000_0005_FFFF_FFFF;
        tv[2] = 64'h0000_0000_0000_0010;
        tv[3] = 64'hFFFF_FFFF_0000_0001;

        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset state
        chk("R1 irq", 64'(irq_out), 64'd0);
        do_read(8'h38, d);
        chk("R1 word", 64'(d), 64'd0);

        // R6, R9, R10: exhaustive sweep of counter vectors
        clear_all();
        for (int tx = 0; tx < (1 << TX_W); tx++) begin
            for (int rx = 0; rx < (1 << RX_W); rx++) begin
                logic [15:0] ew;
                logic        any;
                @(negedge clk);
                tx_cnt_irq = TX_W'(tx); rx_cnt_irq = RX_W'(rx);
                any = (tx != 0) || (rx != 0);
                ew = 16'(((tx != 0) ? 1 : 0) << 6) | 16'(((rx != 0) ? 1 : 0) << 5)
                   | 16'((any ? 1 : 0) << 4);
                do_read(8'h38, d);
                chk("R6 R9 counter word", 64'(d), 64'(ew));
                for (int m = 0; m < 2; m++) begin
                    mmc_mask = m[0];
                    #1;
                    chk("R10 counter irq", 64'(irq_out), 64'(any && m == 0));
                end
                mmc_mask = 1'b0;
            end
        end

        // R2: compare sweep around word boundaries, including equality
        clear_all();
        for (int k = 0; k < 4; k++) begin
            for (int dd = -3; dd <= 3; dd++) begin
                @(negedge clk);
                set_target(tv[k]);
                sys_time = (dd < 0) ? tv[k] - 64'(-dd) : tv[k] + 64'(dd);
                tgt_wr = 1'b1;
                @(posedge clk);
                @(negedge clk);
                tgt_wr = 1'b0;
                @(posedge clk);
                do_read(8'h38, d);
                chk("R2 compare", 64'(d[9]), 64'(dd >= 0));
            end
        end

        // R3, R5: clear on read, no re-fire, re-arm by target write
        clear_all();
        @(negedge clk);
        set_target(64'h100); sys_time = 64'h200;
        @(posedge clk);
        do_read(8'h38, d);
        chk("R3 read returns set bit", 64'(d[9]), 64'd1);
        repeat (3) @(posedge clk);
        do_read(8'h38, d);
        chk("R5 no refire while match holds", 64'(d[9]), 64'd0);
        do_read(8'h38, d);
        chk("R5 still quiet", 64'(d[9]), 64'd0);
        pulse_tgt_wr();
        do_read(8'h38, d);
        chk("R5 rearmed fires", 64'(d[9]), 64'd1);
        pulse_tgt_wr();
        @(posedge clk);
        pulse_tgt_wr();
        do_read(8'h38, d);
        chk("R5 pending with rearm", 64'(d[9]), 64'd1);
        do_read(8'h38, d);
        chk("R5 rearm kept through read", 64'(d[9]), 64'd1);

        // R4: match and read in the same cycle
        clear_all();
        @(negedge clk);
        set_target(64'h100); sys_time = 64'h200;
        rd_en = 1'b1; rd_addr = 8'h38;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        chk("R4 concurrent read sees 0", 64'(rd_data[9]), 64'd0);
        do_read(8'h38, d);
        chk("R4 set wins", 64'(d[9]), 64'd1);

        // R11: other offsets return zero and do not clear
        pulse_tgt_wr();
        @(posedge clk);
        do_read(8'h3C, d);
        chk("R11 other offset zero", 64'(d), 64'd0);
        do_read(8'h00, d);
        chk("R11 offset 0 zero", 64'(d), 64'd0);
        do_read(8'h38, d);
        chk("R11 bit kept", 64'(d[9]), 64'd1);

        // R7, R8: wake flag
        clear_all();
        @(negedge clk); magic_rx = 1'b1;
        @(negedge clk); magic_rx = 1'b0; wkfrm_rx = 1'b1;
        @(negedge clk); wkfrm_rx = 1'b0;
        do_read(8'h38, d);
        chk("R7 ignored outside power-down", 64'(d[3]), 64'd0);
        @(negedge clk); pwr_down = 1'b1; wkfrm_rx = 1'b1;
        @(negedge clk); wkfrm_rx = 1'b0;
        do_read(8'h38, d);
        chk("R7 wake frame sets", 64'(d[3]), 64'd1);
        @(negedge clk); pwr_down = 1'b0;
        do_read(8'h38, d);
        chk("R8 status read keeps", 64'(d[3]), 64'd1);
        @(negedge clk); pm_rd = 1'b1;
        @(negedge clk); pm_rd = 1'b0;
        do_read(8'h38, d);
        chk("R8 pm read clears", 64'(d[3]), 64'd0);
        @(negedge clk); pwr_down = 1'b1; magic_rx = 1'b1; pm_rd = 1'b1;
        @(negedge clk); magic_rx = 1'b0; pm_rd = 1'b0;
        do_read(8'h38, d);
        chk("R8 wake wins over pm read", 64'(d[3]), 64'd1);
        @(negedge clk); magic_rx = 1'b1; pm_rd = 1'b1;
        @(negedge clk); magic_rx = 1'b0; pm_rd = 1'b0;
        do_read(8'h38, d);
        chk("R8 wake wins when already set", 64'(d[3]), 64'd1);

        // R10: every pending pattern against every mask pattern
        for (int p = 0; p < 8; p++) begin
            clear_all();
            @(negedge clk);
            if (p[2]) begin set_target(64'h10); sys_time = 64'h20; end
            if (p[1]) tx_cnt_irq = TX_W'(1);
            if (p[0]) begin pwr_down = 1'b1; magic_rx = 1'b1; end
            @(posedge clk);
            @(negedge clk);
            magic_rx = 1'b0;
            for (int m = 0; m < 8; m++) begin
                ts_mask = m[2]; mmc_mask = m[1]; pmt_mask = m[0];
                #1;
                chk("R10 irq gate", 64'(irq_out), 64'((p & ~m & 7) != 0));
            end
            ts_mask = 1'b0; mmc_mask = 1'b0; pmt_mask = 1'b0;
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule